// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight interrupt request lines, decides which of them may interrupt the processor, and supplies the processor with a jump target when it acknowledges. Each request line is synchronised to the system clock and held in a request register from the cycle its rising edge is seen. A mask register can block any single line. An in-service register records the levels whose handlers are running. The interrupt output rises only when an unmasked pending request outranks every level in service, so a running handler is pre-empted only by a more urgent line.

The processor answers the interrupt with three low pulses on the acknowledge input. During the first pulse the block drives a call opcode onto the 8-bit data bus. During the second pulse it drives the low byte of the handler address, and during the third pulse the high byte. The handler address is a programmable 16-bit base plus four times the level number. When the first pulse starts, the winning request moves from the request register into the in-service register. A small write port loads the mask, the two halves of the base, and an end-of-interrupt command. That command retires the most urgent level in service.

Top module: `vpic_top`

## Requirements
- R1: Each request line passes through a two-stage synchroniser. A rising edge of the synchronised line sets its request bit. While the synchronised line is low, its request bit is cleared, so a request that drops before it is acknowledged is withdrawn.
- R2: Writing `wr_addr`=0 loads the mask. Mask bit i blocks only line i. Masking one line never stops another unmasked line from raising `int_o`.
- R3: Priority is fixed, with line 0 the most urgent and line 7 the least. `int_o` is high exactly when some unmasked pending request has a lower index than the lowest-index bit set in the in-service register, or when that register is empty.
- R4: While `inta_n` is low for the first pulse of a sequence, `dbus_o` carries 8'hCD.
- R5: During the second pulse `dbus_o` carries bits 7:0 of base + 4×level, and during the third pulse it carries bits 15:8. Here level is the one captured at the first pulse. The base low byte is written at `wr_addr`=1 and the high byte at `wr_addr`=2.
- R6: At the first clock edge that sees the first pulse low, the most urgent unmasked pending request sets its in-service bit and clears its request bit. A line that stays high is not requested again until it falls and rises again.
- R7: Writing 8'h20 at `wr_addr`=3 clears the lowest-index set in-service bit. Any other value written at address 3 has no effect.
- R8: `dbus_oe` is high only while `inta_n` is low.
- R9: After reset the mask is 0, the base is 0, no request or in-service bit is set, `int_o` is low and `dbus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 8 | Request lines, bit 0 most urgent |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mask, 1 base low, 2 base high, 3 command |
| wr_data | input | 8 | Write data |
| inta_n | input | 1 | Active-low acknowledge pulses from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| dbus_o | output | 8 | Data bus byte during acknowledge |
| dbus_oe | output | 1 | Data bus output enable |

## Verification
The hardest situation to create from the ports is nested service. In this state a lower-priority line is pending but blocked by a more urgent level in service, while other lines sit high after being serviced and must not request again. The bench builds this state directly: it raises lines in a chosen order, acknowledges between the raises, and then retires levels one at a time with end-of-interrupt writes, including a command write with a wrong value. A seeded random phase then mixes line changes, mask writes, acknowledges and end-of-interrupt commands against a bench model of the request, mask and in-service state. This reaches many more orderings.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam logic [7:0] CALL_OPCODE = 8'hCD;
  localparam logic [7:0] CMD_EOI     = 8'h20;

  typedef enum logic [1:0] {
    SEL_MASK    = 2'd0,
    SEL_BASE_LO = 2'd1,
    SEL_BASE_HI = 2'd2,
    SEL_CMD     = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_OPCODE  = 2'd0,
    PH_ADDR_LO = 2'd1,
    PH_ADDR_HI = 2'd2
  } ack_phase_e;
endpackage

// File: rtl/vpic_req_latch.sv
module vpic_req_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] sync1_q, sync2_q, prev_q, irr_q;
  logic [N-1:0] irr_d;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      always_comb begin
        irr_d[g] = irr_q[g];
        if (sync2_q[g] && !prev_q[g]) irr_d[g] = 1'b1;
        if (!sync2_q[g] || clr[g])    irr_d[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      irr_q   <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      irr_q   <= irr_d;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/vpic_resolver.sv
module vpic_resolver #(
  parameter int unsigned N     = 8,
  parameter int unsigned LVL_W = $clog2(N)
) (
  input  logic [N-1:0]     irr,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     isr,
  output logic             req_any,
  output logic [LVL_W-1:0] req_lvl,
  output logic             isr_any,
  output logic [LVL_W-1:0] isr_lvl,
  output logic             int_req
);
  logic [N-1:0] eligible;
  assign eligible = irr & ~mask;

  always_comb begin
    req_any = 1'b0;
    req_lvl = LVL_W'(N - 1);
    isr_any = 1'b0;
    isr_lvl = LVL_W'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        req_any = 1'b1;
        req_lvl = LVL_W'(i);
      end
      if (isr[i]) begin
        isr_any = 1'b1;
        isr_lvl = LVL_W'(i);
      end
    end
  end

  assign int_req = req_any && (!isr_any || (req_lvl < isr_lvl));
endmodule

// File: rtl/vpic_ack_seq.sv
module vpic_ack_seq
  import vpic_pkg::*;
#(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inta_n,
  input  logic              req_any,
  input  logic [LVL_W-1:0]  req_lvl,
  input  logic [ADDR_W-1:0] base,
  output logic              capture_o,
  output logic [1:0]        phase_o,
  output logic [7:0]        dbus_o,
  output logic              dbus_oe
);
  logic             inta_q;
  ack_phase_e       phase_q, phase_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             fall, rise;
  logic [ADDR_W-1:0] target;

  assign fall = inta_q && !inta_n;
  assign rise = !inta_q && inta_n;
  assign capture_o = fall && (phase_q == PH_OPCODE) && req_any;

  always_comb begin
    phase_d = phase_q;
    lvl_d   = lvl_q;
    if (fall && phase_q == PH_OPCODE) lvl_d = req_any ? req_lvl : LVL_W'((1 << LVL_W) - 1);
    if (rise) begin
      unique case (phase_q)
        PH_OPCODE:  phase_d = PH_ADDR_LO;
        PH_ADDR_LO: phase_d = PH_ADDR_HI;
        default:    phase_d = PH_OPCODE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inta_q  <= 1'b1;
      phase_q <= PH_OPCODE;
      lvl_q   <= '0;
    end else begin
      inta_q  <= inta_n;
      phase_q <= phase_d;
      lvl_q   <= lvl_d;
    end
  end

  assign target = base + ADDR_W'(lvl_q) * ADDR_W'(STRIDE);

  always_comb begin
    unique case (phase_q)
      PH_OPCODE:  dbus_o = CALL_OPCODE;
      PH_ADDR_LO: dbus_o = target[7:0];
      default:    dbus_o = target[15:8];
    endcase
  end

  assign dbus_oe = !inta_n;
  assign phase_o = phase_q;
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned STRIDE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   irq_in,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic         inta_n,
  output logic         int_o,
  output logic [7:0]   dbus_o,
  output logic         dbus_oe
);
  localparam int unsigned LVL_W = $clog2(N);

  logic [1:0] rst_pipe_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  logic [N-1:0]      mask_q, mask_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [N-1:0]      isr_q, isr_d;
  logic [N-1:0]      irr;
  logic [N-1:0]      set_vec, clr_vec;
  logic              req_any, isr_any, int_req, capture, eoi_wr;
  logic [LVL_W-1:0]  req_lvl, isr_lvl;
  logic [1:0]        phase;
  logic              mask_en, base_lo_en, base_hi_en;

  assign mask_en    = wr_en && (wr_addr == SEL_MASK);
  assign base_lo_en = wr_en && (wr_addr == SEL_BASE_LO);
  assign base_hi_en = wr_en && (wr_addr == SEL_BASE_HI);
  assign eoi_wr     = wr_en && (wr_addr == SEL_CMD) && (wr_data == CMD_EOI);

  vpic_req_latch #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_s), .irq_in(irq_in[N-1:0]), .clr(set_vec), .irr_o(irr)
  );

  vpic_resolver #(.N(N), .LVL_W(LVL_W)) u_res (
    .irr(irr), .mask(mask_q), .isr(isr_q),
    .req_any(req_any), .req_lvl(req_lvl),
    .isr_any(isr_any), .isr_lvl(isr_lvl), .int_req(int_req)
  );

  vpic_ack_seq #(.LVL_W(LVL_W), .STRIDE(STRIDE)) u_ack (
    .clk(clk), .rst_n(rst_s), .inta_n(inta_n),
    .req_any(req_any), .req_lvl(req_lvl), .base(base_q),
    .capture_o(capture), .phase_o(phase), .dbus_o(dbus_o), .dbus_oe(dbus_oe)
  );

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (capture)          set_vec[req_lvl] = 1'b1;
    if (eoi_wr && isr_any) clr_vec[isr_lvl] = 1'b1;
    isr_d  = (isr_q & ~clr_vec) | set_vec;
    mask_d = mask_q;
    base_d = base_q;
    if (mask_en)    mask_d = wr_data[N-1:0];
    if (base_lo_en) base_d[7:0]  = wr_data;
    if (base_hi_en) base_d[15:8] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mask_q <= '0;
      base_q <= '0;
      isr_q  <= '0;
    end else begin
      mask_q <= mask_d;
      base_q <= base_d;
      isr_q  <= isr_d;
    end
  end

  assign int_o = int_req;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_s,
  input logic         inta_n,
  input logic         int_o,
  input logic [7:0]   dbus_o,
  input logic         dbus_oe,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr_q,
  input logic [1:0]   phase,
  input logic         capture,
  input logic         eoi_wr
);
  AST_OE_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_s)
    dbus_oe |-> !inta_n); // R8
  AST_CALL_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_s)
    (!inta_n && phase == 2'd0) |-> (dbus_o == 8'hCD)); // R4
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    (mask_q == '1) |-> !int_o); // R2
  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_s)
    int_o |-> ((irr & ~mask_q) != '0)); // R3
  AST_CAPTURE_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_s)
    capture |=> (isr_q != '0)); // R6
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_s)
    (eoi_wr && isr_q != '0 && !capture) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R7
endmodule

bind vpic_top vpic_chk #(.N(N)) chk_i (
  .clk(clk), .rst_s(rst_s), .inta_n(inta_n), .int_o(int_o),
  .dbus_o(dbus_o), .dbus_oe(dbus_oe), .mask_q(mask_q), .irr(irr),
  .isr_q(isr_q), .phase(phase), .capture(capture), .eoi_wr(eoi_wr)
);

// File: tb/vpic_top_tb.sv
`timescale 1ns/1ps
module vpic_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       inta_n;
  logic       int_o;
  logic [7:0] dbus_o;
  logic       dbus_oe;

  always #10 clk = ~clk;

  vpic_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .inta_n(inta_n),
    .int_o(int_o), .dbus_o(dbus_o), .dbus_oe(dbus_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]  m_pend, m_mask, m_isr, m_line;
  logic [15:0] m_base;

  function automatic int best(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int();
    int r, s;
    r = best(m_pend & ~m_mask);
    s = best(m_isr);
    return (r < 8) && (r < s);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lines(input logic [7:0] v);
    m_pend = (m_pend | (v & ~m_line)) & v;
    m_line = v;
    irq_in = v;
    tick(5);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
    case (a)
      2'd0: m_mask = d;
      2'd1: m_base[7:0] = d;
      2'd2: m_base[15:8] = d;
      default: if (d == 8'h20 && m_isr != 0) m_isr[best(m_isr)] = 1'b0;
    endcase
    tick();
  endtask

  task automatic do_ack(input string req);
    int lvl;
    logic [15:0] addr;
    logic [7:0] exp_b [3];
    lvl = best(m_pend & ~m_mask);
    addr = m_base + 16'(lvl * 4);
    exp_b[0] = 8'hCD; exp_b[1] = addr[7:0]; exp_b[2] = addr[15:8];
    for (int p = 0; p < 3; p++) begin
      inta_n = 1'b0;
      tick(2);
      check({req, " R8 oe low pulse"}, 16'(dbus_oe), 16'h1);
      check({req, (p == 0) ? " R4 opcode" : " R5 address byte"}, 16'(dbus_o), 16'(exp_b[p]));
      inta_n = 1'b1;
      tick();
      check({req, " R8 oe released"}, 16'(dbus_oe), 16'h0);
      tick();
    end
    m_isr[lvl]  = 1'b1;
    m_pend[lvl] = 1'b0;
  endtask

  task automatic chk_int(input string req);
    check(req, 16'(int_o), 16'(exp_int()));
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; inta_n = 1'b1;
    m_pend = '0; m_mask = '0; m_isr = '0; m_line = '0; m_base = '0;
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check("R9 reset int", 16'(int_o), 16'h0);
    check("R9 R8 reset oe", 16'(dbus_oe), 16'h0);

    set_lines(8'h08);
    check("R1 R9 line3 raises int", 16'(int_o), 16'h1);
    do_ack("R9 base zero level3");
    check("R6 int falls after capture", 16'(int_o), 16'h0);

    wr(2'd1, 8'h30);
    wr(2'd2, 8'h12);
    set_lines(8'h28);
    check("R3 line5 blocked by level3", 16'(int_o), 16'h0);
    set_lines(8'h2A);
    check("R3 line1 pre-empts level3", 16'(int_o), 16'h1);
    do_ack("R5 base plus level1");

    wr(2'd3, 8'h55);
    chk_int("R7 wrong command ignored");
    wr(2'd3, 8'h20);
    check("R7 first EOI retires level1 only", 16'(int_o), 16'h0);
    wr(2'd3, 8'h20);
    check("R7 second EOI retires level3", 16'(int_o), 16'h1);

    wr(2'd0, 8'h20);
    check("R2 line5 masked", 16'(int_o), 16'h0);
    set_lines(8'h6A);
    check("R2 line6 unaffected by mask5", 16'(int_o), 16'h1);
    do_ack("R3 masked line skipped");
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h20);
    check("R3 line5 after EOI", 16'(int_o), 16'h1);
    set_lines(8'h4A);
    check("R1 withdrawn request", 16'(int_o), 16'h0);
    check("R6 held lines do not re-request", 16'(m_pend), 16'h0);

    for (int it = 0; it < 400; it++) begin
      case ($urandom % 5)
        0, 1: set_lines(8'($urandom));
        2: wr(2'd0, 8'($urandom & $urandom & $urandom));
        3: if (exp_int()) do_ack("R5 random ack");
        default: wr(2'd3, (($urandom % 4) == 0) ? 8'($urandom) : 8'h20);
      endcase
      chk_int("R3 random int");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule